// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block holds a small set of recently used page translations. On each cycle a requester can present a virtual page number together with an access kind (read, write or execute). Every stored entry is compared with that page number at once. If one matches, the block returns the physical frame number, the access rights and the stored status bits in the same cycle. It also flags a protection fault when the rights do not allow the requested access. If nothing matches, a miss is raised so that a page-table walker can fetch the translation.

The walker installs its result through a refill port. A refill whose page number is already present overwrites that entry. Otherwise it goes into the lowest-numbered empty slot, or into a round-robin victim when every slot is occupied. Each hit marks its entry as referenced, and each permitted write hit also marks it dirty. A single-cycle flush empties the whole buffer. Entry count and field widths are parameters, with a default of 16 entries and up to 256.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid, so any lookup misses (`lk_miss`=1, `lk_hit`=0) until a refill is accepted.
- R2: With `lk_valid`=1, `lk_hit` and the returned `lk_pfn`, `lk_rights`, `lk_dirty` and `lk_ref` (the entry's values before this access) appear in the same cycle whenever a valid entry holds `lk_vpn`. Otherwise `lk_miss`=1.
- R3: The rights field has bit 0 = read allowed, bit 1 = write allowed and bit 2 = execute allowed. `lk_kind` is 0 for read, 1 for write, 2 for execute, and 3 is reserved and always denied. `lk_fault`=1 exactly when a hit's rights deny the kind. It is never 1 without a hit.
- R4: Every lookup hit sets the matching entry's referenced bit, which is visible on the next lookup of that page.
- R5: A write hit that is allowed sets the entry's dirty bit. A faulting hit leaves the dirty bit unchanged.
- R6: A refill whose page number matches a valid entry overwrites that entry, so no two valid entries ever hold the same page number.
- R7: A refill of a new page number goes to the lowest-indexed invalid entry while one exists, so no valid translation is displaced.
- R8: When all entries are valid, a new page replaces the entry at a round-robin pointer. The pointer is 0 after reset and advances by one, wrapping, on every accepted refill.
- R9: A newly installed entry is valid, has its referenced bit clear, and takes its dirty bit from `fill_dirty`.
- R10: `flush` invalidates all entries in one cycle. A refill or status update in the same cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | A valid entry matches |
| lk_miss | output | 1 | Request present and no entry matches |
| lk_fault | output | 1 | Hit whose rights deny the access kind |
| lk_pfn | output | PFN_W | Physical frame number of the hit (0 on miss) |
| lk_rights | output | 3 | Rights of the hit: bit 0 read, 1 write, 2 execute |
| lk_dirty | output | 1 | Dirty bit of the hit before this access |
| lk_ref | output | 1 | Referenced bit of the hit before this access |
| fill_valid | input | 1 | Refill request from the walker |
| fill_vpn | input | VPN_W | Page number being installed |
| fill_pfn | input | PFN_W | Frame number being installed |
| fill_rights | input | 3 | Rights being installed |
| fill_dirty | input | 1 | Initial dirty bit |
| flush | input | 1 | Invalidate all entries |

## Verification
Lookups are tried on an empty buffer, on a partly filled one with pages of mixed rights, and on a full one after round-robin evictions. Each case separates correct matching from stale or displaced entries. Read, write, execute and reserved kinds against read-only, read-write and read-execute pages show whether fault detection and dirty marking depend on the rights. Refilling a page that is already present tells overwrite apart from duplication. A refill issued together with a flush shows which of the two takes priority.

// File: rtl/tlb_pkg.sv
// Package: shared access-kind encoding, rights bit positions and the
// permission function used by the buffer. Assumes a 3-bit rights field.
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int RIGHTS_W = 3;
    localparam int RT_READ  = 0;
    localparam int RT_WRITE = 1;
    localparam int RT_EXEC  = 2;

    // Returns 1 when the rights permit the given access kind.
    function automatic logic access_ok(input logic [RIGHTS_W-1:0] rights,
                                       input logic [1:0] kind);
        logic ok;
        case (kind)
            ACC_READ:  ok = rights[RT_READ];
            ACC_WRITE: ok = rights[RT_WRITE];
            ACC_EXEC:  ok = rights[RT_EXEC];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_match.sv
// Module: parallel tag comparator. Compares one key against every entry
// at once and reports the match vector, whether any matched, and the
// lowest matching index. Assumes the caller keeps tags unique among
// valid entries, so the index is exact when at most one bit is set.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
    input  logic [ENTRIES-1:0]            valid,
    input  logic [VPN_W-1:0]              key,
    output logic [ENTRIES-1:0]            match,
    output logic                          any,
    output logic [IDX_W-1:0]              idx
);

    // One comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    // Lowest-index encoder over the match vector.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) idx = IDX_W'(i);
        end
    end

    assign any = |match;

endmodule

// File: rtl/tlb_victim.sv
// Module: refill slot selection. Picks the lowest invalid entry if one
// exists, otherwise the round-robin pointer. The pointer starts at 0
// and advances, wrapping, on every accepted refill.
module tlb_victim #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [ENTRIES-1:0] valid,
    output logic [IDX_W-1:0]   victim
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             has_free;

    // Find the lowest-numbered empty slot.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) free_idx = IDX_W'(i);
        end
    end

    assign has_free = ~&valid;
    assign victim   = has_free ? free_idx : rr_q;

    // Round-robin pointer, stepped once per accepted refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (advance) begin
            rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
        end
    end

endmodule

// File: rtl/tlb_fa.sv
// Module: fully associative translation buffer top. Holds ENTRIES
// translations with tag, frame, rights, dirty, referenced and valid
// fields. Lookup is combinational; status, refill and flush update at
// the clock edge. Priority at the edge: flush, then refill, then hit
// status update. Assumes ENTRIES >= 2 and at most one refill per cycle.
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lk_valid,
    input  logic [VPN_W-1:0]    lk_vpn,
    input  logic [1:0]          lk_kind,
    output logic                lk_hit,
    output logic                lk_miss,
    output logic                lk_fault,
    output logic [PFN_W-1:0]    lk_pfn,
    output logic [RIGHTS_W-1:0] lk_rights,
    output logic                lk_dirty,
    output logic                lk_ref,
    input  logic                fill_valid,
    input  logic [VPN_W-1:0]    fill_vpn,
    input  logic [PFN_W-1:0]    fill_pfn,
    input  logic [RIGHTS_W-1:0] fill_rights,
    input  logic                fill_dirty,
    input  logic                flush
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0][VPN_W-1:0]    tag_q;
    logic [ENTRIES-1:0][PFN_W-1:0]    pfn_q;
    logic [ENTRIES-1:0][RIGHTS_W-1:0] rights_q;
    logic [ENTRIES-1:0]               dirty_q;
    logic [ENTRIES-1:0]               ref_q;
    logic [ENTRIES-1:0]               valid_q;

    logic [ENTRIES-1:0] lk_match_vec;
    logic               lk_any;
    logic [IDX_W-1:0]   hit_idx;
    logic [ENTRIES-1:0] fill_match_vec;
    logic               fill_any;
    logic [IDX_W-1:0]   fill_hit_idx;
    logic [IDX_W-1:0]   victim_idx;
    logic [IDX_W-1:0]   fill_idx;
    logic               fill_go;
    logic               use_go;
    logic               set_dirty;

    // Lookup comparator.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_lk_match (
        .tags  (tag_q),
        .valid (valid_q),
        .key   (lk_vpn),
        .match (lk_match_vec),
        .any   (lk_any),
        .idx   (hit_idx)
    );

    // Refill comparator, used to overwrite an existing copy of the page.
    tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)) u_fill_match (
        .tags  (tag_q),
        .valid (valid_q),
        .key   (fill_vpn),
        .match (fill_match_vec),
        .any   (fill_any),
        .idx   (fill_hit_idx)
    );

    // Victim choice for new pages.
    tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (fill_go),
        .valid   (valid_q),
        .victim  (victim_idx)
    );

    // Lookup result, driven in the request cycle.
    always_comb begin
        lk_hit    = lk_valid && lk_any;
        lk_miss   = lk_valid && !lk_any;
        lk_fault  = lk_hit && !access_ok(rights_q[hit_idx], lk_kind);
        lk_pfn    = lk_hit ? pfn_q[hit_idx]    : '0;
        lk_rights = lk_hit ? rights_q[hit_idx] : '0;
        lk_dirty  = lk_hit && dirty_q[hit_idx];
        lk_ref    = lk_hit && ref_q[hit_idx];
    end

    // Edge control: refill and status-update enables.
    always_comb begin
        fill_go   = fill_valid && !flush;
        fill_idx  = fill_any ? fill_hit_idx : victim_idx;
        use_go    = lk_hit && !flush;
        set_dirty = (lk_kind == ACC_WRITE) && !lk_fault;
    end

    // Entry storage: flush beats refill, refill beats status update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q    <= '0;
            pfn_q    <= '0;
            rights_q <= '0;
            dirty_q  <= '0;
            ref_q    <= '0;
            valid_q  <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (fill_go && fill_idx == IDX_W'(i)) begin
                    tag_q[i]    <= fill_vpn;
                    pfn_q[i]    <= fill_pfn;
                    rights_q[i] <= fill_rights;
                    dirty_q[i]  <= fill_dirty;
                    ref_q[i]    <= 1'b0;
                    valid_q[i]  <= 1'b1;
                end else if (use_go && hit_idx == IDX_W'(i)) begin
                    ref_q[i] <= 1'b1;
                    if (set_dirty) dirty_q[i] <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/tlb_fa_chk.sv
// Module: property checker for tlb_fa, attached by bind. Observes the
// lookup ports, the comparator outputs and the status vectors.
module tlb_fa_chk #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         lk_kind,
    input logic               lk_hit,
    input logic               lk_fault,
    input logic               flush,
    input logic               fill_valid,
    input logic [ENTRIES-1:0] lk_match_vec,
    input logic [ENTRIES-1:0] fill_match_vec,
    input logic [IDX_W-1:0]   hit_idx,
    input logic [ENTRIES-1:0] dirty_q,
    input logic [ENTRIES-1:0] ref_q,
    input logic [ENTRIES-1:0] valid_q
);

    logic [IDX_W-1:0] idx_q;
    logic             dirty_at_q;

    // Remember the hit entry and its dirty bit for next-cycle checks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q      <= '0;
            dirty_at_q <= 1'b0;
        end else begin
            idx_q      <= hit_idx;
            dirty_at_q <= dirty_q[hit_idx];
        end
    end

    // R6
    no_dup_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match_vec));

    // R6
    no_dup_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fill_match_vec));

    // R3
    fault_only_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> lk_hit);

    // R10
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

    // R4
    ref_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && !flush && !fill_valid) |=> ref_q[idx_q]);

    // R5
    dirty_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_kind == 2'd1 && !lk_fault && !flush && !fill_valid)
        |=> dirty_q[idx_q]);

    // R5
    fault_keeps_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit && lk_fault && !flush && !fill_valid)
        |=> (dirty_q[idx_q] == dirty_at_q));

endmodule

bind tlb_fa tlb_fa_chk #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .lk_kind        (lk_kind),
    .lk_hit         (lk_hit),
    .lk_fault       (lk_fault),
    .flush          (flush),
    .fill_valid     (fill_valid),
    .lk_match_vec   (lk_match_vec),
    .fill_match_vec (fill_match_vec),
    .hit_idx        (hit_idx),
    .dirty_q        (dirty_q),
    .ref_q          (ref_q),
    .valid_q        (valid_q)
);

// File: tb/tlb_fa_tb.sv
// Bench: a driver pushes expected lookup results, taken from a model of
// the requirements, into a queue. A monitor pops and compares them at
// mid-cycle.
module tlb_fa_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N      = 16;
    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             lk_valid = 1'b0;
    logic [VPN_W-1:0] lk_vpn = '0;
    logic [1:0]       lk_kind = '0;
    logic             lk_hit, lk_miss, lk_fault, lk_dirty, lk_ref;
    logic [PFN_W-1:0] lk_pfn;
    logic [2:0]       lk_rights;
    logic             fill_valid = 1'b0;
    logic [VPN_W-1:0] fill_vpn = '0;
    logic [PFN_W-1:0] fill_pfn = '0;
    logic [2:0]       fill_rights = '0;
    logic             fill_dirty = 1'b0;
    logic             flush = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_fa #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vpn(lk_vpn), .lk_kind(lk_kind),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
        .lk_pfn(lk_pfn), .lk_rights(lk_rights), .lk_dirty(lk_dirty), .lk_ref(lk_ref),
        .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
        .fill_rights(fill_rights), .fill_dirty(fill_dirty), .flush(flush)
    );

    // Reference model of the buffer contents.
    bit             m_valid [N];
    bit [VPN_W-1:0] m_vpn   [N];
    bit [PFN_W-1:0] m_pfn   [N];
    bit [2:0]       m_rights[N];
    bit             m_dirty [N];
    bit             m_ref   [N];
    int             m_rr = 0;

    typedef struct {
        bit             hit;
        bit             fault;
        bit [PFN_W-1:0] pfn;
        bit [2:0]       rights;
        bit             dirty;
        bit             refb;
        string          req;
    } exp_t;

    exp_t scb[$];

    function automatic bit allowed(bit [2:0] r, bit [1:0] k);
        if (k == 2'd0) return r[0];
        if (k == 2'd1) return r[1];
        if (k == 2'd2) return r[2];
        return 1'b0;
    endfunction

    function automatic int find(bit [VPN_W-1:0] v);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    task automatic cmp(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Monitor: compare at mid-cycle.
    always @(negedge clk) begin
        if (scb.size() > 0) begin
            exp_t e;
            e = scb.pop_front();
            cmp(e.req, "hit", int'(lk_hit), int'(e.hit));
            cmp(e.req, "miss", int'(lk_miss), int'(!e.hit));
            cmp(e.req, "fault", int'(lk_fault), int'(e.fault));
            if (e.hit) begin
                cmp(e.req, "pfn", int'(lk_pfn), int'(e.pfn));
                cmp(e.req, "rights", int'(lk_rights), int'(e.rights));
                cmp(e.req, "dirty", int'(lk_dirty), int'(e.dirty));
                cmp(e.req, "ref", int'(lk_ref), int'(e.refb));
            end
        end
    end

    // Driver: one lookup, with expected result from the model.
    task automatic lookup(bit [VPN_W-1:0] v, bit [1:0] k, string req);
        exp_t e;
        int   ix;
        @(posedge clk); #1;
        lk_valid = 1'b1; lk_vpn = v; lk_kind = k;
        ix = find(v);
        e.req = req;
        e.hit = (ix >= 0);
        e.fault = 0; e.pfn = '0; e.rights = '0; e.dirty = 0; e.refb = 0;
        if (ix >= 0) begin
            e.fault = !allowed(m_rights[ix], k);
            e.pfn = m_pfn[ix]; e.rights = m_rights[ix];
            e.dirty = m_dirty[ix]; e.refb = m_ref[ix];
        end
        scb.push_back(e);
        @(posedge clk);
        if (ix >= 0) begin
            m_ref[ix] = 1'b1;
            if (k == 2'd1 && !e.fault) m_dirty[ix] = 1'b1;
        end
        #1 lk_valid = 1'b0;
    endtask

    // Driver: refill, optionally together with a flush.
    task automatic refill(bit [VPN_W-1:0] v, bit [PFN_W-1:0] p, bit [2:0] r,
                          bit d, bit with_flush);
        int ix;
        @(posedge clk); #1;
        fill_valid = 1'b1; fill_vpn = v; fill_pfn = p; fill_rights = r;
        fill_dirty = d; flush = with_flush;
        @(posedge clk);
        if (with_flush) begin
            for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        end else begin
            ix = find(v);
            if (ix < 0) for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) ix = i;
            if (ix < 0) ix = m_rr;
            m_valid[ix] = 1'b1; m_vpn[ix] = v; m_pfn[ix] = p;
            m_rights[ix] = r; m_dirty[ix] = d; m_ref[ix] = 1'b0;
            m_rr = (m_rr + 1) % N;
        end
        #1 fill_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic do_flush();
        @(posedge clk); #1 flush = 1'b1;
        @(posedge clk);
        for (int i = 0; i < N; i++) m_valid[i] = 1'b0;
        #1 flush = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    // Stimulus.
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        lookup(20'h12345, 2'd0, "R1");

        // R9: install entries of mixed rights
        refill(20'h00010, 20'h00100, 3'b011, 1'b0, 1'b0);
        refill(20'h00020, 20'h00200, 3'b001, 1'b0, 1'b0);
        refill(20'h00030, 20'h00300, 3'b101, 1'b1, 1'b0);

        lookup(20'h00010, 2'd0, "R2 R9");     // hit, ref 0, dirty 0
        lookup(20'h00010, 2'd0, "R4");        // ref now 1
        lookup(20'h00030, 2'd0, "R9");        // dirty taken from refill
        lookup(20'h00040, 2'd0, "R2");        // absent page misses
        lookup(20'h00010, 2'd1, "R5");        // allowed write
        lookup(20'h00010, 2'd0, "R5");        // dirty now 1
        lookup(20'h00020, 2'd1, "R3");        // write to read-only faults
        lookup(20'h00020, 2'd0, "R5");        // dirty still 0
        lookup(20'h00030, 2'd2, "R3");        // execute allowed
        lookup(20'h00020, 2'd2, "R3");        // execute denied
        lookup(20'h00010, 2'd3, "R3");        // reserved kind denied

        // R6: refill of a present page overwrites it
        refill(20'h00010, 20'h00111, 3'b111, 1'b0, 1'b0);
        lookup(20'h00010, 2'd0, "R6");

        // R10: flush, then flush together with refill
        do_flush();
        lookup(20'h00010, 2'd0, "R10");
        lookup(20'h00030, 2'd0, "R10");
        refill(20'h00050, 20'h00500, 3'b111, 1'b0, 1'b1);
        lookup(20'h00050, 2'd0, "R10");

        // R7: fill every slot, nothing is displaced
        for (int i = 0; i < N; i++)
            refill(20'h00100 + 20'(i), 20'h01000 + 20'(i), 3'b001, 1'b0, 1'b0);
        for (int i = 0; i < N; i++)
            lookup(20'h00100 + 20'(i), 2'd0, "R7");

        // R8: round-robin replacement once full
        for (int i = 0; i < 5; i++)
            refill(20'h00200 + 20'(i), 20'h02000 + 20'(i), 3'b011, 1'b0, 1'b0);
        for (int i = 0; i < N; i++)
            lookup(20'h00100 + 20'(i), 2'd0, "R8");
        for (int i = 0; i < 5; i++)
            lookup(20'h00200 + 20'(i), 2'd1, "R8");

        repeat (3) @(posedge clk);
        summary();
    end

endmodule